// File: doc/BRIEF.md
# Scrambling Cartridge ROM Bank Controller

This block sits on the cartridge side of an 8-bit handheld that has a 16-bit CPU address bus. It turns CPU writes into three bank registers and turns CPU reads into a flat physical ROM address. A fixed lower 16 KiB window (CPU 0x0000–0x3FFF) is offset by a base bank. A switchable upper 16 KiB window (CPU 0x4000–0x7FFF) uses a bank number in which the bits selected by a per-bit mask come from the base bank instead of the switchable bank register. The merged bank is then limited to the ROM size.

Writes to the base and mask registers are accepted only while a register-access enable is set. That enable is set or cleared by every write to the switchable bank register, according to a two-bit pattern in the written value.

After reset the controller is in a locked mode. In this mode every lower-window read has address line 7 forced high. The controller also permutes address lines for reads in the cartridge header region. The lock ends after a fixed number of rising edges of the A15 line, or, in a parameter-selected variant, on a read of address 0x0133. Reads at or above 0x8000 do not enable the ROM and request that the bus be driven with 0xFF. The cartridge has no RAM.

Top module: `scram_rom_ctrl`

## Requirements
- R1: After reset the switchable bank is 1. A write to 0x2000–0x3FFF loads it with the write data, except that a value of 0 is stored as 1.
- R2: Each write to 0x2000–0x3FFF sets the register-access enable when data bits 5 and 4 are both 1, and clears it otherwise. After reset the enable is clear.
- R3: A write to 0x0000–0x1FFF loads the base bank (reset value 0) only while the register-access enable is set. Otherwise the base bank is unchanged.
- R4: A write to 0x4000–0x5FFF loads the bank mask (reset value 0) only while the register-access enable is set. Otherwise the mask is unchanged.
- R5: A read in 0x4000–0x7FFF gives rom_addr_o = {bank_eff, addr[13:0]}. Here bank_eff = ((bank & ~mask) | (mask & base)) & (ROM_BANKS-1).
- R6: A read in 0x0000–0x3FFF gives rom_addr_o = {base truncated to the bank bits, lower offset}. The lower offset is addr[13:0], modified by R7 and R8.
- R7: For reads in 0x0100–0x01FF, offset bit 0 takes address bit 6, bit 6 takes bit 0, bit 1 takes bit 4, and bit 4 takes bit 1. All other bits pass through unchanged.
- R8: The controller is locked after reset. While locked, offset bit 7 of every lower-window read is forced to 1, and this is applied after the R7 swap.
- R9: In the default variant the lock clears on the 31st rising edge of a15_i seen after reset, and it stays locked after 30 edges. In the read variant it clears on a read of 0x0133. Once cleared, it never sets again.
- R10: A read with addr[15]=1 gives ff_o=1 and rom_oe_o=0. A read below 0x8000 gives rom_oe_o=1 and ff_o=0. With rd_i low, both outputs are 0.
- R11: Writes to 0x6000–0xFFFF change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wr_i | input | 1 | Write strobe, sampled on the clock edge |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| a15_i | input | 1 | A15 line used for lock release |
| rom_addr_o | output | ROM_AW | Physical ROM byte address |
| rom_oe_o | output | 1 | ROM output enable (read below 0x8000) |
| ff_o | output | 1 | Drive 0xFF on the data bus (read at or above 0x8000) |

## Verification
The assertions check the following on every cycle:
- the enables are mutually exclusive and follow rd_i and addr[15];
- the bank register never holds zero;
- the base and mask registers hold their value when a write arrives with access disabled;
- the lock never reasserts;
- the low 14 offset bits pass through unchanged in the upper window, and in the unlocked lower window outside the header.

Only the bench scenarios can show the following:
- the exact merged bank values under different masks and ROM-size truncation;
- the header bit permutation combined with the forced bit 7;
- the exact edge count at which the lock releases.

// File: rtl/scram_rom_pkg.sv
package scram_rom_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_BANK = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [2:0] top3);
    case (top3)
      3'd0:    return SEL_BASE;
      3'd1:    return SEL_BANK;
      3'd2:    return SEL_MASK;
      default: return SEL_NONE;
    endcase
  endfunction

  // header line permutation: swap 0<->6 and 1<->4
  function automatic logic [13:0] hdr_permute(input logic [13:0] a);
    logic [13:0] r;
    r    = a;
    r[0] = a[6];
    r[6] = a[0];
    r[1] = a[4];
    r[4] = a[1];
    return r;
  endfunction
endpackage

// File: rtl/scram_reg_file.sv
module scram_reg_file
  import scram_rom_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [15:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] bank_o,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              acc_o
);
  reg_sel_e sel;
  logic [12:0] unused_addr;

  assign sel         = decode_sel(addr_i[15:13]);
  assign unused_addr = addr_i[12:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= DATA_W'(1);
      base_o <= '0;
      mask_o <= '0;
      acc_o  <= 1'b0;
    end else if (wr_i) begin
      case (sel)
        SEL_BANK: begin
          bank_o <= (wdata_i == '0) ? DATA_W'(1) : wdata_i;
          acc_o  <= &wdata_i[5:4];
        end
        SEL_BASE: if (acc_o) base_o <= wdata_i;
        SEL_MASK: if (acc_o) mask_o <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scram_lock_ctrl.sv
module scram_lock_ctrl #(
  parameter bit UNLOCK_ON_READ = 1'b0,
  parameter int LOCK_EDGES     = 31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        a15_i,
  input  logic        rd_i,
  input  logic [15:0] addr_i,
  output logic        locked_o
);
  localparam int CNT_W = $clog2(LOCK_EDGES + 1);

  if (UNLOCK_ON_READ) begin : g_rd
    logic unused_a15;
    assign unused_a15 = a15_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           locked_o <= 1'b1;
      else if (rd_i && addr_i == 16'h0133)   locked_o <= 1'b0;
    end
  end else begin : g_edge
    logic             a15_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;
    logic [16:0]      unused_rd;

    assign unused_rd = {rd_i, addr_i};
    assign rise      = a15_i & ~a15_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a15_q    <= 1'b0;
        cnt_q    <= '0;
        locked_o <= 1'b1;
      end else begin
        a15_q <= a15_i;
        if (rise && locked_o) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(LOCK_EDGES - 1)) locked_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/scram_addr_map.sv
module scram_addr_map
  import scram_rom_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BANK_AW = 6,
  parameter int ROM_AW  = BANK_AW + 14
) (
  input  logic [15:0]       addr_i,
  input  logic              rd_i,
  input  logic              locked_i,
  input  logic [DATA_W-1:0] bank_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_oe_o,
  output logic              ff_o
);
  logic [13:0]       low_off;
  logic [DATA_W-1:0] merged;

  always_comb begin
    low_off = (addr_i[15:8] == 8'h01) ? hdr_permute(addr_i[13:0]) : addr_i[13:0];
    if (locked_i) low_off[7] = 1'b1;
    merged = (bank_i & ~mask_i) | (mask_i & base_i);
    if (addr_i[14]) rom_addr_o = {merged[BANK_AW-1:0], addr_i[13:0]};
    else            rom_addr_o = {base_i[BANK_AW-1:0], low_off};
  end

  assign rom_oe_o = rd_i & ~addr_i[15];
  assign ff_o     = rd_i &  addr_i[15];
endmodule

// File: rtl/scram_rom_ctrl.sv
module scram_rom_ctrl #(
  parameter int ROM_BANKS      = 64,
  parameter bit UNLOCK_ON_READ = 1'b0,
  parameter int LOCK_EDGES     = 31,
  localparam int DATA_W        = 8,
  localparam int BANK_AW       = $clog2(ROM_BANKS),
  localparam int ROM_AW        = BANK_AW + 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  input  logic              a15_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_oe_o,
  output logic              ff_o
);
  logic [DATA_W-1:0] bank_q, base_q, mask_q;
  logic              acc_q, locked_q;

  scram_reg_file #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .bank_o(bank_q), .base_o(base_q), .mask_o(mask_q), .acc_o(acc_q)
  );

  scram_lock_ctrl #(.UNLOCK_ON_READ(UNLOCK_ON_READ), .LOCK_EDGES(LOCK_EDGES)) u_lock (
    .clk_i, .rst_ni, .a15_i, .rd_i, .addr_i, .locked_o(locked_q)
  );

  scram_addr_map #(.DATA_W(DATA_W), .BANK_AW(BANK_AW), .ROM_AW(ROM_AW)) u_map (
    .addr_i, .rd_i, .locked_i(locked_q),
    .bank_i(bank_q), .base_i(base_q), .mask_i(mask_q),
    .rom_addr_o, .rom_oe_o, .ff_o
  );
endmodule

// File: rtl/scram_rom_ctrl_chk.sv
module scram_rom_ctrl_chk #(
  parameter int ROM_AW = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic              rom_oe_o,
  input logic              ff_o,
  input logic [7:0]        bank_q,
  input logic [7:0]        base_q,
  input logic [7:0]        mask_q,
  input logic              acc_q,
  input logic              locked_q
);
  assert_bank_nonzero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_q != 8'd0);

  assert_base_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'd0 && !acc_q) |=> $stable(base_q));

  assert_mask_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'd2 && !acc_q) |=> $stable(mask_q));

  assert_upper_offset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b01) |-> (rom_addr_o[13:0] == addr_i[13:0]));

  assert_plain_lower_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00 && addr_i[15:8] != 8'h01 && !locked_q)
      |-> (rom_addr_o[13:0] == addr_i[13:0]));

  assert_lock_bit7_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00 && locked_q) |-> rom_addr_o[7]);

  assert_lock_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_q |=> !locked_q);

  assert_enables_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rom_oe_o, ff_o}) == {1'b0, rd_i} && (ff_o == (rd_i && addr_i[15])));
endmodule

bind scram_rom_ctrl scram_rom_ctrl_chk #(.ROM_AW(ROM_AW)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .rom_addr_o, .rom_oe_o, .ff_o,
  .bank_q, .base_q, .mask_q, .acc_q, .locked_q
);

// File: tb/scram_rom_ctrl_test.sv
module scram_rom_ctrl_test;
  localparam int ROM_BANKS = 64;
  localparam int ROM_AW    = $clog2(ROM_BANKS) + 14;

  typedef struct {
    logic [ROM_AW-1:0] ra;
    logic              oe;
    logic              ff;
    string             tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, a15 = 1'b0;
  logic [7:0] wdata = '0;
  logic [ROM_AW-1:0] rom_addr;
  logic rom_oe, ff;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  item_t q[$];
  item_t mon_it;

  logic [7:0] m_bank = 8'd1, m_base = 8'd0, m_mask = 8'd0;
  bit m_acc = 1'b0, m_locked = 1'b1;

  always #4 clk = ~clk;

  scram_rom_ctrl #(.ROM_BANKS(ROM_BANKS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .a15_i(a15), .rom_addr_o(rom_addr), .rom_oe_o(rom_oe), .ff_o(ff)
  );

  function automatic logic [ROM_AW-1:0] model_addr(input logic [15:0] a);
    logic [13:0] off;
    logic [7:0]  eff;
    off = a[13:0];
    if (a >= 16'h0100 && a <= 16'h01FF) begin
      off[6] = a[0]; off[0] = a[6]; off[4] = a[1]; off[1] = a[4];
    end
    if (m_locked) off[7] = 1'b1;
    eff = ((m_bank & ~m_mask) | (m_mask & m_base)) & 8'(ROM_BANKS - 1);
    if (a < 16'h4000) return (ROM_AW'(m_base) & ROM_AW'(ROM_BANKS - 1)) * 20'h4000 + ROM_AW'(off);
    return ROM_AW'(eff) * 20'h4000 + ROM_AW'(a[13:0]);
  endfunction

  task automatic do_read(input logic [15:0] a, input bit en, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a; rd = en;
    it.ra  = model_addr(a);
    it.oe  = en && a < 16'h8000;
    it.ff  = en && a >= 16'h8000;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
    case (a[15:13])
      3'd0: if (m_acc) m_base = d;
      3'd1: begin m_bank = (d == 0) ? 8'd1 : d; m_acc = (d[5] && d[4]); end
      3'd2: if (m_acc) m_mask = d;
      default: ;
    endcase
  endtask

  task automatic pulse_a15(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; a15 = 1'b1;
      @(posedge clk); #1; a15 = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      mon_it = q.pop_front();
      checks++;
      if (rom_oe !== mon_it.oe || ff !== mon_it.ff || (mon_it.oe && rom_addr !== mon_it.ra)) begin
        fails++;
        $display("FAIL %s: got addr=%h oe=%b ff=%b, expected addr=%h oe=%b ff=%b",
                 mon_it.tag, rom_addr, rom_oe, ff, mon_it.ra, mon_it.oe, mon_it.ff);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    do_read(16'h4123, 1, "R1 reset bank 1");
    do_read(16'h0050, 1, "R8 reset locked bit7");
    do_read(16'h0133, 1, "R7 header swap with lock");
    do_read(16'h8000, 1, "R10 high read 0xFF");
    do_read(16'h1234, 0, "R10 idle no enables");
    do_write(16'h2000, 8'h00);
    do_read(16'h7FFF, 1, "R1 zero stored as 1");
    do_write(16'h0000, 8'h03);
    do_read(16'h0050, 1, "R3 base ignored without access");
    do_write(16'h2100, 8'h35);
    do_write(16'h1000, 8'h02);
    do_write(16'h4000, 8'h03);
    do_read(16'h4ABC, 1, "R5 masked merge");
    do_read(16'h0234, 1, "R6 lower offset by base");
    do_write(16'h2000, 8'h45);
    do_write(16'h5000, 8'hFF);
    do_read(16'h4000, 1, "R4 mask ignored without access");
    do_write(16'h0000, 8'h07);
    do_read(16'h0010, 1, "R2 access cleared by pattern");
    do_write(16'h6000, 8'h00);
    do_write(16'hA000, 8'h00);
    do_read(16'h4001, 1, "R11 out-of-range writes ignored");
    do_write(16'h3000, 8'h30);
    do_write(16'h4000, 8'h00);
    do_read(16'h4000, 1, "R2 access set by 0x30");
    do_write(16'h2000, 8'hF0);
    do_read(16'h4444, 1, "R5 ROM size truncation");
    do_read(16'hFFFF, 1, "R10 top read 0xFF");
    pulse_a15(30);
    do_read(16'h0050, 1, "R9 still locked after 30 edges");
    pulse_a15(1);
    m_locked = 1'b0;
    do_read(16'h0050, 1, "R9 unlocked after 31 edges");
    do_read(16'h0133, 1, "R7 header swap unlocked");
    do_read(16'h01D3, 1, "R7 header swap pattern 2");
    do_read(16'h0200, 1, "R7 outside header untouched");
    pulse_a15(3);
    do_read(16'h00C0, 1, "R9 lock stays clear");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule